// File: doc/BRIEF.md
# Shared Buffer Memory Arbiter

This block sits in front of the frame-buffer memory bus of a multi-port switch. It gives the bus to one port at a time. Each port can raise three kinds of request:

- continue a frame that is already going out;
- store received data into a free buffer;
- begin sending a frame that waits in its queue.

In every memory cycle the arbiter grants at most one request. The class decides first: continuing transmissions come before receive, and receive comes before starting transmissions. Inside a class, grants rotate round-robin. The management port, which is the highest port index, is served in a class only when no network port wants that class.

The arbiter also owns the count of free buffers. Every receive grant takes one buffer and every release pulse returns one. When the pool is empty, receive requests are refused and each refused port gets a drop pulse. When the count falls to a programmable low-water mark and flow control is enabled, a flow-control request goes out. It is held until the count climbs past the mark plus a programmable hysteresis.

Top module: `mem_bus_arbiter`

## Requirements
- R1: While rst_ni is low and after its release, grant_o is 0, grant_valid_o is 0, grant_class_o is 0, rx_drop_o is 0, fc_req_o is 0 and free_cnt_o equals DEPTH.
- R2: A transmit-continue request is granted ahead of any receive or transmit-start request in the same cycle; grant_class_o is 1.
- R3: Receive requests are granted (grant_class_o 2) only when no transmit-continue request is pending and free_cnt_o is nonzero.
- R4: A transmit-start request (grant_class_o 3) is granted only in a cycle with no transmit-continue request and no grantable receive request.
- R5: Each class keeps its own round-robin pointer: among the requesting network ports, the grant goes to the first index above the port last granted in that class, wrapping around. After reset, every pointer sits at the top network index, so port 0 is tried first.
- R6: Port NET_PORTS (the management port) is granted in a class only when no network port requests that class, and a management grant does not move that class's pointer.
- R7: Requests sampled at a rising edge produce, after that edge, a one-hot grant_o, the matching grant_port_o, grant_valid_o high and the class code (1 continue, 2 receive, 3 start). With no request, grant_o is 0, grant_valid_o 0 and grant_class_o 0.
- R8: free_cnt_o drops by one on each receive grant and rises by one on each buf_release_i pulse, never above DEPTH; a release and a receive grant in the same cycle leave it unchanged.
- R9: With fc_en_i high, fc_req_o rises one cycle after free_cnt_o is at or below fc_thresh_i.
- R10: fc_req_o stays high until free_cnt_o exceeds fc_thresh_i + fc_hyst_i (one cycle later it falls), and is low one cycle after fc_en_i is low.
- R11: While free_cnt_o is 0, each port with a receive request gets a one-cycle rx_drop_o bit in the grant cycle, and no receive grant is made; otherwise rx_drop_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_cont_req_i | input | NET_PORTS+1 | Per-port request to continue a transmission in progress |
| rx_req_i | input | NET_PORTS+1 | Per-port request to store received data |
| tx_start_req_i | input | NET_PORTS+1 | Per-port request to begin a queued transmission |
| buf_release_i | input | 1 | One buffer returned to the free pool |
| fc_en_i | input | 1 | Flow-control enable |
| fc_thresh_i | input | CW | Low-water mark of the free count |
| fc_hyst_i | input | CW | Hysteresis added to the mark for release |
| grant_o | output | NET_PORTS+1 | One-hot grant |
| grant_valid_o | output | 1 | A grant is issued this cycle |
| grant_port_o | output | PW | Index of the granted port |
| grant_class_o | output | 2 | 0 none, 1 continue, 2 receive, 3 start |
| rx_drop_o | output | NET_PORTS+1 | Receive refused, pool empty |
| fc_req_o | output | 1 | Flow-control request |
| free_cnt_o | output | CW | Free buffers in the pool |

## Verification
The hardest states to reach are an empty pool with receive requests still pending, and the band between the low-water mark and the mark plus hysteresis, where flow control must hold its last value. The stimulus uses long receive bursts to drain the pool, one grant per cycle, until it is empty. It then offers receive requests together with a start request, so that the drops and the fallback to the lowest class are seen together. After that it returns buffers one at a time, walking the count up through the hysteresis band to full and beyond. Every cycle goes through a reference model, so each pointer rotation and every count step are compared.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_TX_CONT  = 2'd1,
    CLS_RX       = 2'd2,
    CLS_TX_START = 2'd3
  } cls_e;

  localparam int unsigned NUM_CLS = 3;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = arb_pkg::idx_w(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [IW-1:0] k;

  // search starts one past the last winner
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    k     = '0;
    for (int off = 1; off <= int'(N); off++) begin
      k = IW'((int'(last_i) + off) % int'(N));
      if (!any_o && req_i[k]) begin
        any_o    = 1'b1;
        gnt_o[k] = 1'b1;
        idx_o    = k;
      end
    end
  end
endmodule

// File: rtl/arb_free_pool.sv
module arb_free_pool #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          release_i,
  input  logic          fc_en_i,
  input  logic [CW-1:0] thresh_i,
  input  logic [CW-1:0] hyst_i,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          fc_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fc_q, fc_d;
  logic [CW:0]   release_lvl;

  assign release_lvl = {1'b0, thresh_i} + {1'b0, hyst_i};

  always_comb begin
    cnt_d = cnt_q;
    if (alloc_i && !release_i)                        cnt_d = cnt_q - 1'b1;
    else if (release_i && !alloc_i && cnt_q != FULL)  cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    fc_d = fc_q;
    if (!fc_en_i)                               fc_d = 1'b0;
    else if (cnt_q <= thresh_i)                 fc_d = 1'b1;
    else if ({1'b0, cnt_q} > release_lvl)       fc_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= FULL;
      fc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fc_q  <= fc_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign fc_o    = fc_q;
endmodule

// File: rtl/mem_bus_arbiter.sv
module mem_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NET_PORTS = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned P         = NET_PORTS + 1,
  parameter int unsigned PW        = $clog2(NET_PORTS + 1),
  parameter int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [P-1:0]  tx_cont_req_i,
  input  logic [P-1:0]  rx_req_i,
  input  logic [P-1:0]  tx_start_req_i,
  input  logic          buf_release_i,
  input  logic          fc_en_i,
  input  logic [CW-1:0] fc_thresh_i,
  input  logic [CW-1:0] fc_hyst_i,
  output logic [P-1:0]  grant_o,
  output logic          grant_valid_o,
  output logic [PW-1:0] grant_port_o,
  output logic [1:0]    grant_class_o,
  output logic [P-1:0]  rx_drop_o,
  output logic          fc_req_o,
  output logic [CW-1:0] free_cnt_o
);
  localparam int unsigned NIW  = idx_w(NET_PORTS);
  localparam int unsigned MGMT = NET_PORTS;

  logic                 pool_empty;
  logic [P-1:0]         cls_req [NUM_CLS];
  logic [NET_PORTS-1:0] net_gnt [NUM_CLS];
  logic [NIW-1:0]       net_idx [NUM_CLS];
  logic                 net_any [NUM_CLS];
  logic [NIW-1:0]       last_q  [NUM_CLS];

  logic          sel_vld, sel_net;
  int unsigned   sel_c;
  logic [P-1:0]  sel_gnt;
  logic [PW-1:0] sel_port;
  logic [NIW-1:0] sel_idx;
  logic          rx_alloc;

  always_comb begin
    cls_req[0] = tx_cont_req_i;
    cls_req[1] = pool_empty ? '0 : rx_req_i;
    cls_req[2] = tx_start_req_i;
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    arb_rr_pick #(.N(NET_PORTS), .IW(NIW)) u_rr (
      .req_i  (cls_req[c][NET_PORTS-1:0]),
      .last_i (last_q[c]),
      .gnt_o  (net_gnt[c]),
      .idx_o  (net_idx[c]),
      .any_o  (net_any[c])
    );
  end

  // walk from lowest class up so the highest class wins
  always_comb begin
    sel_vld  = 1'b0;
    sel_net  = 1'b0;
    sel_c    = 0;
    sel_gnt  = '0;
    sel_port = '0;
    sel_idx  = '0;
    for (int c = NUM_CLS - 1; c >= 0; c--) begin
      if (net_any[c]) begin
        sel_vld  = 1'b1;
        sel_net  = 1'b1;
        sel_c    = c;
        sel_gnt  = {1'b0, net_gnt[c]};
        sel_port = PW'(net_idx[c]);
        sel_idx  = net_idx[c];
      end else if (cls_req[c][MGMT]) begin
        sel_vld  = 1'b1;
        sel_net  = 1'b0;
        sel_c    = c;
        sel_gnt  = '0;
        sel_gnt[MGMT] = 1'b1;
        sel_port = PW'(MGMT);
        sel_idx  = '0;
      end
    end
  end

  assign rx_alloc = sel_vld && (sel_c == 1);

  arb_free_pool #(.DEPTH(DEPTH), .CW(CW)) u_pool (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alloc_i   (rx_alloc),
    .release_i (buf_release_i),
    .fc_en_i   (fc_en_i),
    .thresh_i  (fc_thresh_i),
    .hyst_i    (fc_hyst_i),
    .cnt_o     (free_cnt_o),
    .empty_o   (pool_empty),
    .fc_o      (fc_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CLS; c++) last_q[c] <= NIW'(NET_PORTS - 1);
    end else if (sel_vld && sel_net) begin
      last_q[sel_c] <= sel_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o       <= '0;
      grant_valid_o <= 1'b0;
      grant_port_o  <= '0;
      grant_class_o <= CLS_NONE;
      rx_drop_o     <= '0;
    end else begin
      grant_o       <= sel_gnt;
      grant_valid_o <= sel_vld;
      grant_port_o  <= sel_port;
      grant_class_o <= sel_vld ? 2'(sel_c + 1) : CLS_NONE;
      rx_drop_o     <= pool_empty ? rx_req_i : '0;
    end
  end
endmodule

// File: rtl/mem_bus_arbiter_chk.sv
module mem_bus_arbiter_chk #(
  parameter int unsigned NET_PORTS = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned P         = NET_PORTS + 1,
  parameter int unsigned CW        = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [P-1:0]  tx_cont_req_i,
  input logic [P-1:0]  rx_req_i,
  input logic          fc_en_i,
  input logic [P-1:0]  grant_o,
  input logic          grant_valid_o,
  input logic [1:0]    grant_class_o,
  input logic [P-1:0]  rx_drop_o,
  input logic          fc_req_o,
  input logic [CW-1:0] free_cnt_o
);
  // R7
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

  // R7
  class_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o == (grant_class_o != 2'd0));

  // R3
  rx_needs_buffer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_class_o == 2'd2) |-> ($past(free_cnt_o) != '0 && $past(tx_cont_req_i) == '0));

  // R4
  start_is_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_class_o == 2'd3) |->
      ($past(tx_cont_req_i) == '0 && ($past(rx_req_i) == '0 || $past(free_cnt_o) == '0)));

  // R11
  drop_only_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_drop_o != '0) |-> ($past(free_cnt_o) == '0 && grant_class_o != 2'd2));

  // R8
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt_o <= CW'(DEPTH));

  // R10
  fc_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fc_en_i) |-> !fc_req_o);
endmodule

bind mem_bus_arbiter mem_bus_arbiter_chk #(
  .NET_PORTS (NET_PORTS),
  .DEPTH     (DEPTH)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_cont_req_i (tx_cont_req_i),
  .rx_req_i      (rx_req_i),
  .fc_en_i       (fc_en_i),
  .grant_o       (grant_o),
  .grant_valid_o (grant_valid_o),
  .grant_class_o (grant_class_o),
  .rx_drop_o     (rx_drop_o),
  .fc_req_o      (fc_req_o),
  .free_cnt_o    (free_cnt_o)
);

// File: tb/mem_bus_arbiter_test.sv
module mem_bus_arbiter_test;
  localparam int NET   = 4;
  localparam int DEPTH = 16;
  localparam int P     = NET + 1;
  localparam int PW    = $clog2(NET + 1);
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [P-1:0]  txc = '0, rx = '0, txs = '0;
  logic          rel = 1'b0, fc_en = 1'b0;
  logic [CW-1:0] th = '0, hy = '0;
  logic [P-1:0]  grant, drop;
  logic          vld, fc;
  logic [PW-1:0] port;
  logic [1:0]    cls;
  logic [CW-1:0] cnt;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_bus_arbiter #(.NET_PORTS(NET), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_cont_req_i(txc), .rx_req_i(rx), .tx_start_req_i(txs),
    .buf_release_i(rel), .fc_en_i(fc_en), .fc_thresh_i(th), .fc_hyst_i(hy),
    .grant_o(grant), .grant_valid_o(vld), .grant_port_o(port), .grant_class_o(cls),
    .rx_drop_o(drop), .fc_req_o(fc), .free_cnt_o(cnt)
  );

  typedef struct {
    logic [P-1:0]  gnt;
    logic          vld;
    int            port;
    int            cls;
    logic [P-1:0]  drop;
    logic          fc;
    int            cnt;
    string         tag;
  } exp_t;

  exp_t q[$];

  // reference state
  int m_cnt = DEPTH;
  bit m_fc = 0;
  int m_last[3] = '{NET - 1, NET - 1, NET - 1};

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [P-1:0] c, input logic [P-1:0] r, input logic [P-1:0] s,
                       input logic rl, input string tag);
    exp_t e;
    logic [P-1:0] req[3];
    bit rx_ok, fc_n, alloc;
    @(negedge clk);
    txc = c; rx = r; txs = s; rel = rl;
    rx_ok = (m_cnt != 0);
    if (!fc_en) fc_n = 0;
    else if (m_cnt <= int'(th)) fc_n = 1;
    else if (m_cnt > int'(th) + int'(hy)) fc_n = 0;
    else fc_n = m_fc;
    req[0] = c; req[1] = rx_ok ? r : '0; req[2] = s;
    e.gnt = '0; e.vld = 0; e.port = 0; e.cls = 0; e.tag = tag;
    for (int k = 0; k < 3 && !e.vld; k++) begin
      for (int off = 1; off <= NET && !e.vld; off++) begin
        int i;
        i = (m_last[k] + off) % NET;
        if (req[k][i]) begin
          e.vld = 1; e.port = i; e.cls = k + 1; e.gnt[i] = 1'b1; m_last[k] = i;
        end
      end
      if (!e.vld && req[k][NET]) begin
        e.vld = 1; e.port = NET; e.cls = k + 1; e.gnt[NET] = 1'b1;
      end
    end
    alloc = (e.cls == 2);
    e.drop = rx_ok ? '0 : r;
    if (alloc && !rl) m_cnt--;
    else if (rl && !alloc && m_cnt < DEPTH) m_cnt++;
    m_fc = fc_n;
    e.fc = fc_n;
    e.cnt = m_cnt;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive('0, '0, '0, 1'b0, tag);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(grant == e.gnt, e.tag, "grant", int'(grant), int'(e.gnt));
      chk(vld == e.vld, e.tag, "valid", int'(vld), int'(e.vld));
      if (e.vld) chk(int'(port) == e.port, e.tag, "port", int'(port), e.port);
      chk(int'(cls) == e.cls, e.tag, "class", int'(cls), e.cls);
      chk(drop == e.drop, e.tag, "drop", int'(drop), int'(e.drop));
      chk(fc == e.fc, e.tag, "fc", int'(fc), int'(e.fc));
      chk(int'(cnt) == e.cnt, e.tag, "count", int'(cnt), e.cnt);
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    th = CW'(3); hy = CW'(2); fc_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(grant == '0 && !vld && cls == 2'd0, "R1", "grant", int'(grant), 0);
    chk(drop == '0 && !fc, "R1", "drop_fc", int'(drop) + int'(fc), 0);
    chk(int'(cnt) == DEPTH, "R1", "count", int'(cnt), DEPTH);
    rst_n = 1'b1;

    idle("R7");
    drive('0, '0, 5'b00100, 0, "R4");
    drive(5'b00010, 5'b01000, 5'b00001, 0, "R2");
    drive('0, 5'b01000, 5'b00001, 0, "R3");
    repeat (3) drive('0, '0, 5'b00101, 0, "R5");
    repeat (4) drive('0, 5'b00101, '0, 0, "R5");
    drive('0, 5'b10010, '0, 0, "R6");
    drive('0, 5'b10000, '0, 0, "R6");
    drive(5'b10000, '0, 5'b00001, 0, "R6");
    drive('0, 5'b10001, '0, 0, "R6");
    idle("R7");
    // drain the pool; flow control rises near empty
    repeat (12) drive('0, 5'b00011, '0, 0, "R9");
    drive('0, 5'b00011, 5'b00100, 0, "R11");
    drive('0, 5'b10000, '0, 0, "R11");
    drive('0, '0, '0, 1, "R8");
    drive('0, 5'b00001, '0, 1, "R8");
    drive('0, 5'b00010, '0, 0, "R8");
    // climb through the hysteresis band
    repeat (8) drive('0, '0, '0, 1, "R10");
    repeat (12) drive('0, '0, '0, 1, "R8");
    drive('0, 5'b00100, '0, 1, "R8");
    repeat (12) drive('0, 5'b01000, '0, 0, "R9");
    fc_en = 1'b0;
    repeat (3) drive('0, 5'b00100, '0, 0, "R10");
    idle("R7");
    idle("R7");
    wait (q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule